// File: doc/BRIEF.md
# Masked Event Interrupt Controller

This block collects up to eight event flags in a pending register and qualifies them with an eight-bit enable mask. It drives an active-low interrupt line whenever an enabled event is pending. Software clears events through an acknowledge command, which returns the pending state as a short byte stream. When a peripheral reply is waiting, the acknowledge instead returns only the reply-related flags followed by the reply payload, and leaves the other events pending.

Two timers are built in, and both count milliseconds derived from a clock-enable input. The first is a one-second tick that sets the tick event and never drifts. The second is a poll timer: while its device-select mask is nonzero it requests a peripheral poll every few milliseconds. Poll results and command replies are written into a small reply buffer through a write port, and a commit strobe then marks them pending.

Top module: `evt_irq_ctrl`

## Requirements
- R1: `irq_n` is low exactly when the pending register ANDed with the enable mask is nonzero. It follows a change of either register in the next cycle.
- R2: After reset the pending register is 0 and the mask is 8'h18, which enables the reply event (bit 4) and the tick event (bit 3). `irq_n` is high, no response byte is valid, and the poll timer is stopped with `poll_sel` = 0.
- R3: A command with `cmd_op` = 1 and `cmd_argc` = 1 loads `cmd_arg` into the mask. With any other argument count the command leaves the mask unchanged.
- R4: An acknowledge (`cmd_op` = 0, `cmd_argc` = 0) accepted while bit 4 is clear returns one byte equal to the whole pending register and clears that register. An acknowledge with a nonzero `cmd_argc` changes nothing.
- R5: An acknowledge accepted while bit 4 is set returns a header byte equal to pending AND 8'h11 (reply bit 4, auto-poll bit 0). The header is followed by the committed reply bytes, buffer address 0 first. Bits 4 and 0 and the stored reply length are then cleared, and all other pending bits remain.
- R6: Response bytes are held on `rsp_data` while `rsp_valid` is high and `rsp_ready` is low. A byte advances on a cycle with `rsp_ready` high, and `rsp_last` marks the final byte. An acknowledge that arrives while a stream is in progress is ignored.
- R7: The tick event (bit 3) is set once every TICK_MS × CYC_PER_MS pulses of `time_ce`, measured from reset with no accumulated drift.
- R8: While `poll_sel` is nonzero, `poll_fire` pulses once every POLL_MS milliseconds. The pulse is suppressed, while the timer keeps running, when bit 4 is pending.
- R9: A poll mask write of zero stops the poll timer. A write of a nonzero value different from the current one stores it and restarts the poll period from zero. A write equal to the current value has no effect.
- R10: A commit with `rbuf_from_poll` = 0 sets bit 4. A commit with `rbuf_from_poll` = 1 sets bits 4 and 0, but while bit 4 is already pending, poll-sourced buffer writes and commits are ignored. A commit stores `rbuf_len`, which is capped at RB_DEPTH, as the reply length.
- R11: Bits on `evt_set` are ORed into the pending register. If a set and an acknowledge clear hit the same bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| time_ce | input | 1 | Time-base clock enable; CYC_PER_MS pulses form one millisecond |
| evt_set | input | 8 | Event set strobes, one per pending bit |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 1 | 0 = acknowledge, 1 = mask write |
| cmd_argc | input | 4 | Number of argument bytes carried by the command |
| cmd_arg | input | 8 | First argument byte (new mask value) |
| rsp_valid | output | 1 | Response byte available |
| rsp_data | output | 8 | Response byte |
| rsp_last | output | 1 | Current byte is the last of the response |
| rsp_ready | input | 1 | Consumer takes the current response byte |
| rbuf_we | input | 1 | Reply buffer write enable |
| rbuf_addr | input | 3 | Reply buffer byte address |
| rbuf_wdata | input | 8 | Reply buffer write data |
| rbuf_commit | input | 1 | Marks the reply buffer contents pending |
| rbuf_len | input | 4 | Reply length in bytes, used with the commit |
| rbuf_from_poll | input | 1 | Write or commit comes from an automatic poll |
| pollmask_we | input | 1 | Poll device-select mask write |
| pollmask | input | 16 | New poll device-select mask |
| poll_sel | output | 16 | Current poll device-select mask |
| poll_fire | output | 1 | One-cycle request to poll the selected devices |
| irq_n | output | 1 | Active-low interrupt |

## Verification
If the pending register or the mask holds a wrong bit, `irq_n` shows it in the very next cycle. The next acknowledge then exposes the whole register in its first response byte. A reply length or buffer fault appears only at the next reply acknowledge, as a wrong byte count or wrong payload in the stream. Timer counter errors are the slowest to surface: a poll period fault shows within one poll period on `poll_fire`, and a tick fault only after a full second of `time_ce` pulses, as a late or early change of `irq_n`. The bench therefore compares every output against its model on every cycle and runs long enough to cover one full tick period.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

    localparam int EVT_W     = 8;
    localparam int BIT_AUTO  = 0;
    localparam int BIT_TICK  = 3;
    localparam int BIT_REPLY = 4;

    // bits reported and cleared by an acknowledge while a reply waits
    localparam logic [EVT_W-1:0] REPLY_BITS = (EVT_W'(1) << BIT_REPLY) | (EVT_W'(1) << BIT_AUTO);
    // enables after reset: reply and tick
    localparam logic [EVT_W-1:0] MASK_INIT  = (EVT_W'(1) << BIT_REPLY) | (EVT_W'(1) << BIT_TICK);

    typedef enum logic {
        OP_ACK     = 1'b0,
        OP_SETMASK = 1'b1
    } cmd_op_e;

endpackage

// File: rtl/evt_timebase.sv
module evt_timebase #(
    parameter int CYC_PER_MS = 1000,
    parameter int TICK_MS    = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic time_ce,
    output logic ms_stb,
    output logic sec_stb
);
    localparam int MW = $clog2(CYC_PER_MS + 1);
    localparam int SW = $clog2(TICK_MS + 1);

    typedef struct packed {
        logic [MW-1:0] ms_cnt;
        logic [SW-1:0] sec_cnt;
    } tb_t;

    tb_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        ms_stb  = time_ce && (st_q.ms_cnt == MW'(CYC_PER_MS - 1));
        sec_stb = ms_stb && (st_q.sec_cnt == SW'(TICK_MS - 1));
        if (time_ce) begin
            st_d.ms_cnt = ms_stb ? '0 : st_q.ms_cnt + 1'b1;
        end
        if (ms_stb) begin
            // wrap to zero exactly at the target: period is fixed, no drift
            st_d.sec_cnt = sec_stb ? '0 : st_q.sec_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/evt_poll_timer.sv
module evt_poll_timer #(
    parameter int POLL_MS = 30,
    parameter int SEL_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ms_stb,
    input  logic             sel_we,
    input  logic [SEL_W-1:0] sel_wdata,
    input  logic             reply_busy,
    output logic [SEL_W-1:0] poll_sel,
    output logic             poll_fire
);
    localparam int PW = $clog2(POLL_MS + 1);

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic [PW-1:0]    cnt;
    } pt_t;

    pt_t  st_d, st_q;
    logic running;
    logic expire;

    always_comb begin
        st_d      = st_q;
        running   = (st_q.sel != '0);
        expire    = running && ms_stb && (st_q.cnt == PW'(POLL_MS - 1));
        poll_fire = expire && !reply_busy;
        if (running && ms_stb) begin
            st_d.cnt = expire ? '0 : st_q.cnt + 1'b1;
        end
        if (sel_we && (sel_wdata != st_q.sel)) begin
            st_d.sel = sel_wdata;
            st_d.cnt = '0;
        end
    end

    assign poll_sel = st_q.sel;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/evt_reply_buf.sv
module evt_reply_buf #(
    parameter int DEPTH = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [AW-1:0]      addr,
    input  logic [7:0]         wdata,
    output logic [DEPTH*8-1:0] rd_all
);
    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        logic [7:0] ent_d, ent_q;

        always_comb begin
            ent_d = ent_q;
            if (we && (addr == AW'(g))) ent_d = wdata;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) ent_q <= '0;
            else        ent_q <= ent_d;
        end

        assign rd_all[g*8 +: 8] = ent_q;
    end

endmodule

// File: rtl/evt_rsp_stream.sv
module evt_rsp_stream #(
    parameter int DEPTH = 8,
    localparam int N    = DEPTH + 1,
    localparam int IW   = $clog2(N),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [7:0]         hdr,
    input  logic [DEPTH*8-1:0] payload,
    input  logic [LW-1:0]      plen,
    input  logic               rsp_ready,
    output logic               rsp_valid,
    output logic [7:0]         rsp_data,
    output logic               rsp_last
);
    typedef struct packed {
        logic              busy;
        logic [IW-1:0]     idx;
        logic [IW-1:0]     last;
        logic [N-1:0][7:0] sh;
    } rs_t;

    rs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.busy  = 1'b1;
            st_d.idx   = '0;
            st_d.last  = IW'(plen);
            st_d.sh[0] = hdr;
            for (int i = 0; i < DEPTH; i++) begin
                st_d.sh[i+1] = payload[i*8 +: 8];
            end
        end else if (st_q.busy && rsp_ready) begin
            if (st_q.idx == st_q.last) st_d.busy = 1'b0;
            else                       st_d.idx  = st_q.idx + 1'b1;
        end
    end

    assign rsp_valid = st_q.busy;
    assign rsp_data  = st_q.sh[st_q.idx];
    assign rsp_last  = st_q.busy && (st_q.idx == st_q.last);

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
    import evt_irq_pkg::*;
#(
    parameter int CYC_PER_MS = 1000,
    parameter int TICK_MS    = 1000,
    parameter int POLL_MS    = 30,
    parameter int RB_DEPTH   = 8,
    parameter int SEL_W      = 16,
    localparam int RB_AW     = (RB_DEPTH > 1) ? $clog2(RB_DEPTH) : 1,
    localparam int RB_LW     = $clog2(RB_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             time_ce,
    input  logic [EVT_W-1:0] evt_set,
    input  logic             cmd_valid,
    input  logic             cmd_op,
    input  logic [3:0]       cmd_argc,
    input  logic [7:0]       cmd_arg,
    output logic             rsp_valid,
    output logic [7:0]       rsp_data,
    output logic             rsp_last,
    input  logic             rsp_ready,
    input  logic             rbuf_we,
    input  logic [RB_AW-1:0] rbuf_addr,
    input  logic [7:0]       rbuf_wdata,
    input  logic             rbuf_commit,
    input  logic [RB_LW-1:0] rbuf_len,
    input  logic             rbuf_from_poll,
    input  logic             pollmask_we,
    input  logic [SEL_W-1:0] pollmask,
    output logic [SEL_W-1:0] poll_sel,
    output logic             poll_fire,
    output logic             irq_n
);
    typedef struct packed {
        logic [EVT_W-1:0] pend;
        logic [EVT_W-1:0] mask;
        logic [RB_LW-1:0] rsize;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [EVT_W-1:0]    pend_q, mask_q;
    logic                ms_stb, sec_stb;
    logic                reply_pend;
    logic                ack_ok, mwr_ok;
    logic                poll_blocked, buf_we, commit_ok;
    logic [EVT_W-1:0]    set_v, clr_v;
    logic [7:0]          hdr;
    logic [RB_LW-1:0]    plen;
    logic [RB_DEPTH*8-1:0] buf_all;

    assign pend_q     = ctl_q.pend;
    assign mask_q     = ctl_q.mask;
    assign reply_pend = ctl_q.pend[BIT_REPLY];

    evt_timebase #(
        .CYC_PER_MS(CYC_PER_MS),
        .TICK_MS   (TICK_MS)
    ) u_timebase (
        .clk    (clk),
        .rst_n  (rst_n),
        .time_ce(time_ce),
        .ms_stb (ms_stb),
        .sec_stb(sec_stb)
    );

    evt_poll_timer #(
        .POLL_MS(POLL_MS),
        .SEL_W  (SEL_W)
    ) u_poll (
        .clk       (clk),
        .rst_n     (rst_n),
        .ms_stb    (ms_stb),
        .sel_we    (pollmask_we),
        .sel_wdata (pollmask),
        .reply_busy(reply_pend),
        .poll_sel  (poll_sel),
        .poll_fire (poll_fire)
    );

    evt_reply_buf #(
        .DEPTH(RB_DEPTH)
    ) u_rbuf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (buf_we),
        .addr  (rbuf_addr),
        .wdata (rbuf_wdata),
        .rd_all(buf_all)
    );

    evt_rsp_stream #(
        .DEPTH(RB_DEPTH)
    ) u_stream (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ack_ok),
        .hdr      (hdr),
        .payload  (buf_all),
        .plen     (plen),
        .rsp_ready(rsp_ready),
        .rsp_valid(rsp_valid),
        .rsp_data (rsp_data),
        .rsp_last (rsp_last)
    );

    // command qualification
    assign ack_ok = cmd_valid && (cmd_op_e'(cmd_op) == OP_ACK) && (cmd_argc == 4'd0) && !rsp_valid;
    assign mwr_ok = cmd_valid && (cmd_op_e'(cmd_op) == OP_SETMASK) && (cmd_argc == 4'd1);

    // a poll result may not overwrite a reply that is still waiting
    assign poll_blocked = rbuf_from_poll && reply_pend;
    assign buf_we       = rbuf_we && !poll_blocked;
    assign commit_ok    = rbuf_commit && !poll_blocked;

    // acknowledge header and payload length
    assign hdr  = reply_pend ? (ctl_q.pend & REPLY_BITS) : ctl_q.pend;
    assign plen = reply_pend ? ctl_q.rsize : '0;

    always_comb begin
        ctl_d = ctl_q;
        clr_v = '0;
        set_v = evt_set;

        if (ack_ok) begin
            if (reply_pend) begin
                clr_v       = REPLY_BITS;
                ctl_d.rsize = '0;
            end else begin
                clr_v = '1;
            end
        end

        if (sec_stb) set_v[BIT_TICK] = 1'b1;

        if (commit_ok) begin
            set_v[BIT_REPLY] = 1'b1;
            if (rbuf_from_poll) set_v[BIT_AUTO] = 1'b1;
            ctl_d.rsize = (rbuf_len > RB_LW'(RB_DEPTH)) ? RB_LW'(RB_DEPTH) : rbuf_len;
        end

        // set after clear: a simultaneous event is never lost
        ctl_d.pend = (ctl_q.pend & ~clr_v) | set_v;

        if (mwr_ok) ctl_d.mask = cmd_arg;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.pend  <= '0;
            ctl_q.mask  <= MASK_INIT;
            ctl_q.rsize <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign irq_n = ~|(ctl_q.pend & ctl_q.mask);

endmodule

// File: rtl/evt_irq_chk.sv
module evt_irq_chk #(
    parameter int SEL_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       evt_set,
    input logic             cmd_valid,
    input logic             cmd_op,
    input logic [3:0]       cmd_argc,
    input logic             rsp_valid,
    input logic             rsp_ready,
    input logic [7:0]       rsp_data,
    input logic [SEL_W-1:0] poll_sel,
    input logic             poll_fire,
    input logic [7:0]       pend_q,
    input logic [7:0]       mask_q
);
    logic ack_take;
    assign ack_take = cmd_valid && (cmd_op == 1'b0) && (cmd_argc == 4'd0) && !rsp_valid;

    // R3: the mask moves only on a well-formed mask write
    assert_mask_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && cmd_op && (cmd_argc == 4'd1)) |=> $stable(mask_q));

    // R4: full acknowledge returns the whole register
    assert_ack_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_take && !pend_q[4]) |=> (rsp_valid && (rsp_data == $past(pend_q))));

    // R5: reply acknowledge header carries only reply and auto-poll bits
    assert_ack_hdr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_take && pend_q[4]) |=> (rsp_valid && (rsp_data == ($past(pend_q) & 8'h11))));

    // R6: a stalled byte is held
    assert_rsp_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

    // R8: no poll request while a reply waits or while stopped
    assert_poll_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        poll_fire |-> (!pend_q[4] && (poll_sel != '0)));

    // R11: a set strobe always lands
    assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_set != 8'h00) |=> ((pend_q & $past(evt_set)) == $past(evt_set)));

endmodule

bind evt_irq_ctrl evt_irq_chk #(.SEL_W(SEL_W)) u_evt_irq_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_set  (evt_set),
    .cmd_valid(cmd_valid),
    .cmd_op   (cmd_op),
    .cmd_argc (cmd_argc),
    .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready),
    .rsp_data (rsp_data),
    .poll_sel (poll_sel),
    .poll_fire(poll_fire),
    .pend_q   (pend_q),
    .mask_q   (mask_q)
);

// File: tb/test_evt_irq_ctrl.sv
module test_evt_irq_ctrl;

    localparam int CPM   = 2;
    localparam int TMS   = 1000;
    localparam int PMS   = 30;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        s_ce = 1'b0;
    logic [7:0]  s_evt = '0;
    logic        s_cv = 1'b0;
    logic        s_op = 1'b0;
    logic [3:0]  s_argc = '0;
    logic [7:0]  s_arg = '0;
    logic        s_ready = 1'b1;
    logic        s_we = 1'b0;
    logic [2:0]  s_addr = '0;
    logic [7:0]  s_wd = '0;
    logic        s_commit = 1'b0;
    logic [3:0]  s_len = '0;
    logic        s_fpoll = 1'b0;
    logic        s_pmwe = 1'b0;
    logic [15:0] s_pm = '0;

    logic        rsp_valid, rsp_last, poll_fire, irq_n;
    logic [7:0]  rsp_data;
    logic [15:0] poll_sel;

    always #10 clk = ~clk;

    evt_irq_ctrl #(
        .CYC_PER_MS(CPM), .TICK_MS(TMS), .POLL_MS(PMS), .RB_DEPTH(DEPTH), .SEL_W(16)
    ) i_evt_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .time_ce(s_ce), .evt_set(s_evt),
        .cmd_valid(s_cv), .cmd_op(s_op), .cmd_argc(s_argc), .cmd_arg(s_arg),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_last(rsp_last), .rsp_ready(s_ready),
        .rbuf_we(s_we), .rbuf_addr(s_addr), .rbuf_wdata(s_wd), .rbuf_commit(s_commit),
        .rbuf_len(s_len), .rbuf_from_poll(s_fpoll), .pollmask_we(s_pmwe), .pollmask(s_pm),
        .poll_sel(poll_sel), .poll_fire(poll_fire), .irq_n(irq_n)
    );

    // reference model state
    int m_ms = 0, m_sec = 0, m_pend = 0, m_mask = 8'h18, m_rsize = 0;
    int m_sel = 0, m_pcnt = 0;
    int m_buf [DEPTH];
    int m_rsp [$];
    int n_chk = 0, n_err = 0;
    string cur_req = "R2";
    bit  last_fire = 1'b0;
    bit  done = 1'b0;

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endtask

    function automatic bit ms_tick_now();
        return s_ce && (m_ms == CPM - 1);
    endfunction

    task automatic compare_outputs();
        bit exp_fire;
        exp_fire = (m_sel != 0) && ms_tick_now() && (m_pcnt == PMS - 1) && (((m_pend >> 4) & 1) == 0);
        last_fire = exp_fire;
        chk("irq_n", {31'd0, irq_n}, ((m_pend & m_mask) == 0) ? 32'd1 : 32'd0);
        chk("rsp_valid", {31'd0, rsp_valid}, (m_rsp.size() > 0) ? 32'd1 : 32'd0);
        if (m_rsp.size() > 0) begin
            chk("rsp_data", {24'd0, rsp_data}, 32'(m_rsp[0]));
            chk("rsp_last", {31'd0, rsp_last}, (m_rsp.size() == 1) ? 32'd1 : 32'd0);
        end
        chk("poll_fire", {31'd0, poll_fire}, {31'd0, exp_fire});
        chk("poll_sel", {16'd0, poll_sel}, 32'(m_sel));
    endtask

    task automatic model_step();
        bit tk, sec, reply, blocked, ack, expire;
        int clr, setv;
        tk      = ms_tick_now();
        sec     = tk && (m_sec == TMS - 1);
        reply   = ((m_pend >> 4) & 1) != 0;
        blocked = s_fpoll && reply;
        ack     = s_cv && !s_op && (s_argc == 0) && (m_rsp.size() == 0);
        clr = 0;
        setv = s_evt;
        if (m_rsp.size() > 0 && s_ready) void'(m_rsp.pop_front());
        if (ack) begin
            if (reply) begin
                m_rsp.push_back(m_pend & 8'h11);
                for (int i = 0; i < m_rsize; i++) m_rsp.push_back(m_buf[i]);
                clr = 8'h11;
                m_rsize = 0;
            end else begin
                m_rsp.push_back(m_pend);
                clr = 8'hFF;
            end
        end
        if (s_we && !blocked) m_buf[s_addr] = s_wd;
        if (sec) setv = setv | 8'h08;
        if (s_commit && !blocked) begin
            setv = setv | (s_fpoll ? 8'h11 : 8'h10);
            m_rsize = (s_len > DEPTH) ? DEPTH : s_len;
        end
        m_pend = ((m_pend & ~clr) | setv) & 8'hFF;
        if (s_cv && s_op && s_argc == 1) m_mask = s_arg;
        if (s_ce) m_ms = tk ? 0 : m_ms + 1;
        if (tk) m_sec = sec ? 0 : m_sec + 1;
        expire = (m_sel != 0) && tk && (m_pcnt == PMS - 1);
        if ((m_sel != 0) && tk) m_pcnt = expire ? 0 : m_pcnt + 1;
        if (s_pmwe && (s_pm != m_sel)) begin
            m_sel  = s_pm;
            m_pcnt = 0;
        end
    endtask

    // one clock: inputs already set at the falling edge
    task automatic cycle();
        #1;
        compare_outputs();
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        s_evt = '0; s_cv = 1'b0; s_op = 1'b0; s_argc = '0; s_arg = '0;
        s_we = 1'b0; s_commit = 1'b0; s_fpoll = 1'b0; s_len = '0; s_pmwe = 1'b0;
    endtask

    task automatic run(input int n);
        for (int k = 0; k < n; k++) cycle();
    endtask

    task automatic pulse_ack(input int argc);
        s_cv = 1'b1; s_op = 1'b0; s_argc = 4'(argc);
        cycle();
        idle_inputs();
    endtask

    task automatic pulse_mask(input int argc, input int val);
        s_cv = 1'b1; s_op = 1'b1; s_argc = 4'(argc); s_arg = 8'(val);
        cycle();
        idle_inputs();
    endtask

    task automatic write_pm(input int val);
        s_pmwe = 1'b1; s_pm = 16'(val);
        cycle();
        idle_inputs();
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) m_buf[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2: reset state
        cur_req = "R2";
        run(4);
        chk("reset irq_n", {31'd0, irq_n}, 32'd1);
        chk("reset poll_sel", {16'd0, poll_sel}, 32'd0);

        // R1 / R11: masked and unmasked events
        cur_req = "R1";
        s_evt = 8'h02; cycle(); idle_inputs();
        run(2);
        chk("bit1 masked, irq_n", {31'd0, irq_n}, 32'd1);
        s_evt = 8'h08; cycle(); idle_inputs();
        chk("tick bit enabled, irq_n", {31'd0, irq_n}, 32'd0);

        // R3: mask writes
        cur_req = "R3";
        pulse_mask(2, 8'hFF);
        pulse_mask(0, 8'hFF);
        run(2);
        pulse_mask(1, 8'h02);
        run(2);

        // R4: acknowledge of the full register
        cur_req = "R4";
        pulse_ack(1);
        run(2);
        chk("ack with argument ignored, irq_n", {31'd0, irq_n}, 32'd0);
        pulse_ack(0);
        chk("full ack byte", {24'd0, rsp_data}, 32'h0A);
        run(3);
        chk("cleared, irq_n", {31'd0, irq_n}, 32'd1);

        // R10: command reply into the buffer
        cur_req = "R10";
        pulse_mask(1, 8'h13);
        for (int i = 0; i < 3; i++) begin
            s_we = 1'b1; s_addr = 3'(i); s_wd = 8'(8'hA0 + i);
            cycle();
        end
        idle_inputs();
        s_commit = 1'b1; s_len = 4'd3; cycle(); idle_inputs();
        s_evt = 8'h02; cycle(); idle_inputs();
        // poll result while reply waits: ignored
        s_we = 1'b1; s_addr = 3'd0; s_wd = 8'h55; s_fpoll = 1'b1; s_commit = 1'b1; s_len = 4'd1;
        cycle(); idle_inputs();
        run(2);

        // R5 / R6: reply acknowledge with a stalled consumer
        cur_req = "R5";
        s_ready = 1'b0;
        pulse_ack(0);
        chk("reply header", {24'd0, rsp_data}, 32'h10);
        cur_req = "R6";
        run(3);
        pulse_ack(0);
        run(2);
        s_ready = 1'b1;
        cycle();
        chk("first payload byte", {24'd0, rsp_data}, 32'hA0);
        s_ready = 1'b0;
        run(2);
        s_ready = 1'b1;
        run(4);
        cur_req = "R5";
        chk("other bit kept, irq_n", {31'd0, irq_n}, 32'd0);
        pulse_ack(0);
        chk("remaining byte", {24'd0, rsp_data}, 32'h02);
        run(2);

        // R11: set and clear in the same cycle
        cur_req = "R11";
        s_evt = 8'h04; s_cv = 1'b1; s_argc = 4'd0;
        cycle(); idle_inputs();
        run(2);
        pulse_mask(1, 8'h04);
        run(1);
        chk("set survives clear, irq_n", {31'd0, irq_n}, 32'd0);
        pulse_ack(0);
        run(2);
        pulse_mask(1, 8'h19);

        // R8 / R9 / R10 / R7: timers with a steady time base
        cur_req = "R8";
        s_ce = 1'b1;
        write_pm(16'h0003);
        for (int k = 0; k < 400; k++) begin
            if (last_fire) begin
                s_we = 1'b1; s_addr = 3'd0; s_wd = 8'(k); s_commit = 1'b1; s_len = 4'd1; s_fpoll = 1'b1;
            end
            cycle();
            idle_inputs();
            if (k % 97 == 96) pulse_ack(0);
        end
        cur_req = "R9";
        write_pm(16'h0003);
        run(50);
        write_pm(16'h0300);
        run(150);
        write_pm(16'h0000);
        run(100);
        write_pm(16'h0001);
        cur_req = "R7";
        run(1600);
        chk("tick seen, irq_n", {31'd0, irq_n}, 32'd0);
        pulse_ack(0);
        run(4);

        // R7 / R8: time base with gaps
        cur_req = "R8";
        for (int k = 0; k < 300; k++) begin
            s_ce = (k % 3) != 0;
            cycle();
        end
        s_ce = 1'b0;
        run(4);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule